// File: doc/BRIEF.md
# Two-Wire Bus Target with Strap-Selected Address

This block is the serial front end of a monitoring device that answers on a two-wire system-management bus. It samples the clock and data lines with the system clock. It finds start and stop conditions, shifts in the address byte and decides whether to acknowledge it. After a write address it takes the first data byte as a register pointer. It then turns each following byte into a one-cycle write strobe toward an internal register file. After a read address it shifts out the register value at the pointer.

The 7-bit bus address is not fixed. Two strap inputs choose one of three addresses while the block is unlocked. The first transaction whose five high address bits fit the family prefix freezes that choice. A transaction with a foreign prefix, such as a bus glitch, never locks the block. When the locking transaction ends with a stop, the block hands the shared strap pins back to their normal functions through a select output. Data is driven open-drain: the block only ever pulls the line low.

Top module: `smb_strap_slave`

## Requirements
- R1: After reset the data pull-down, the write strobe and the pin-return select are all low, and the block is unlocked.
- R2: While unlocked, the address is 0101110 when the enable strap is 1, whatever the select strap is. It is 0101100 when both straps are 0, and 0101101 when the enable strap is 0 and the select strap is 1. A matching address byte is acknowledged by pulling data low during the ninth clock.
- R3: An address byte whose high five bits are not 01011 is not acknowledged and does not lock the address. Later strap changes still take effect.
- R4: The straps are captured in the cycle the first address byte with prefix 01011 is judged. From then on, strap changes have no effect on which address is acknowledged.
- R5: The pin-return select goes high at the stop that ends the locking transaction and stays high until reset. It is low before that stop.
- R6: In a write, every data byte is acknowledged. The first data byte after the address loads the register pointer and gives no strobe. Each later byte gives one strobe carrying that byte at the current pointer, and the pointer then advances by one.
- R7: In a read, the register value at the pointer is sent most significant bit first, one bit per clock. A master acknowledge (data low on the ninth clock) starts another byte from the same pointer. A master non-acknowledge makes the block release data until the next start.
- R8: The data pull-down changes only while the synchronized clock is low.
- R9: A stop at any point releases data and returns the block to idle, and a partial byte is dropped. A repeated start restarts address reception and keeps the pointer.
- R10: After locking, an address byte with the right prefix but a different 7-bit address is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| strap_en_i | input | 1 | Address enable strap level |
| strap_sel_i | input | 1 | Address select strap level |
| pins_normal_o | output | 1 | 1 hands the shared strap pins back to normal use |
| reg_ptr_o | output | 8 | Register pointer toward the register file |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_data_o | output | 8 | Write data, valid with the strobe |
| rd_data_i | input | 8 | Register value at the pointer |

## Verification
On every cycle the checker confirms several properties. The data pull-down stays still while the clock is high and drops after any stop. The lock and the pin-return select never fall back, and the select is only high once locked. The locked address holds, and each strobe is a single cycle followed by a pointer advance of one. Only the directed scenarios can show the rest. These are the strap-to-address mapping and the acknowledge bit on the ninth clock, a foreign-prefix glitch leaving the block unlocked, and the exact strobe data and pointers. They also cover read bit order with master acknowledge and non-acknowledge, and the recovery after a stop that cuts a byte short.

// File: rtl/smb_pkg.sv
package smb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WR,
      ST_WACK,
      ST_RD,
      ST_MACK,
      ST_SKIP
   } smb_state_e;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic lvl_o,
   output logic prv_o
);

   logic [STAGES-1:0] chain_q;
   logic              prv_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("smb_line_sync: STAGES must be at least 2");
      end
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[0], line_i};
         end
      end else begin : g_long
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], line_i};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prv_q <= 1'b1;
      else        prv_q <= chain_q[STAGES-1];
   end

   assign lvl_o = chain_q[STAGES-1];
   assign prv_o = prv_q;

endmodule

// File: rtl/smb_addr_strap.sv
module smb_addr_strap #(
   parameter int          ADDR_W  = 7,
   parameter int          HI_W    = 5,
   parameter logic [4:0]  ADDR_HI = 5'b01011,
   parameter logic [1:0]  LO_EN   = 2'b10,
   parameter logic [1:0]  LO_SEL0 = 2'b00,
   parameter logic [1:0]  LO_SEL1 = 2'b01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_en_i,
   input  logic              strap_sel_i,
   input  logic              lock_req_i,
   input  logic              stop_i,
   output logic [ADDR_W-1:0] eff_addr_o,
   output logic              locked_o,
   output logic              pins_normal_o
);

   localparam int LO_W = ADDR_W - HI_W;

   logic [LO_W-1:0]   strap_lo;
   logic [ADDR_W-1:0] strap_addr;
   logic [ADDR_W-1:0] lock_addr_q;
   logic              locked_q;
   logic              normal_q;

   generate
      if (LO_W != 2) begin : g_bad_lo
         $error("smb_addr_strap: strap field must be two bits wide");
      end
   endgenerate

   always_comb begin
      if (strap_en_i)        strap_lo = LO_EN;
      else if (strap_sel_i)  strap_lo = LO_SEL1;
      else                   strap_lo = LO_SEL0;
   end

   assign strap_addr = {ADDR_HI[HI_W-1:0], strap_lo};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q    <= 1'b0;
         lock_addr_q <= '0;
         normal_q    <= 1'b0;
      end else begin
         if (lock_req_i && !locked_q) begin
            locked_q    <= 1'b1;
            lock_addr_q <= strap_addr;
         end
         if (stop_i && locked_q) normal_q <= 1'b1;
      end
   end

   assign eff_addr_o    = locked_q ? lock_addr_q : strap_addr;
   assign locked_o      = locked_q;
   assign pins_normal_o = normal_q;

endmodule

// File: rtl/smb_byte_fsm.sv
module smb_byte_fsm import smb_pkg::*; #(
   parameter int         DATA_W  = 8,
   parameter int         ADDR_W  = 7,
   parameter int         HI_W    = 5,
   parameter logic [4:0] ADDR_HI = 5'b01011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise_i,
   input  logic              scl_fall_i,
   input  logic              sda_lvl_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic [ADDR_W-1:0] eff_addr_i,
   output logic              lock_req_o,
   output logic              sda_oe_o,
   output logic [DATA_W-1:0] ptr_o,
   output logic              wr_stb_o,
   output logic [DATA_W-1:0] wr_data_o,
   input  logic [DATA_W-1:0] rd_data_i
);

   localparam int              CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] FULL  = CNT_W'(DATA_W);

   smb_state_e        st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] sh_q;
   logic              oe_q;
   logic [DATA_W-1:0] ptr_q;
   logic              ptr_first_q;
   logic              stb_q;
   logic [DATA_W-1:0] wdat_q;
   logic              mack_q;
   logic              lock_q;
   logic              hi_match;
   logic              full_match;

   assign hi_match   = (sh_q[DATA_W-1 -: HI_W] == ADDR_HI[HI_W-1:0]);
   assign full_match = hi_match && (sh_q[DATA_W-1:1] == eff_addr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         cnt_q       <= '0;
         sh_q        <= '0;
         oe_q        <= 1'b0;
         ptr_q       <= '0;
         ptr_first_q <= 1'b1;
         stb_q       <= 1'b0;
         wdat_q      <= '0;
         mack_q      <= 1'b0;
         lock_q      <= 1'b0;
      end else begin
         stb_q  <= 1'b0;
         lock_q <= 1'b0;
         if (stb_q) ptr_q <= ptr_q + 1'b1;
         if (start_i) begin
            st_q        <= ST_ADDR;
            cnt_q       <= '0;
            oe_q        <= 1'b0;
            ptr_first_q <= 1'b1;
         end else if (stop_i) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            oe_q  <= 1'b0;
         end else begin
            case (st_q)
               ST_ADDR, ST_WR: begin
                  if (scl_rise_i && cnt_q < FULL) begin
                     sh_q  <= {sh_q[DATA_W-2:0], sda_lvl_i};
                     cnt_q <= cnt_q + 1'b1;
                  end else if (scl_fall_i && cnt_q == FULL) begin
                     cnt_q <= '0;
                     if (st_q == ST_ADDR) begin
                        if (hi_match) lock_q <= 1'b1;
                        if (full_match) begin
                           oe_q <= 1'b1;
                           st_q <= ST_AACK;
                        end else begin
                           st_q <= ST_SKIP;
                        end
                     end else begin
                        oe_q <= 1'b1;
                        st_q <= ST_WACK;
                        if (ptr_first_q) begin
                           ptr_q       <= sh_q;
                           ptr_first_q <= 1'b0;
                        end else begin
                           stb_q  <= 1'b1;
                           wdat_q <= sh_q;
                        end
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall_i) begin
                     cnt_q <= '0;
                     if (sh_q[0]) begin
                        sh_q <= rd_data_i;
                        oe_q <= ~rd_data_i[DATA_W-1];
                        st_q <= ST_RD;
                     end else begin
                        oe_q <= 1'b0;
                        st_q <= ST_WR;
                     end
                  end
               end
               ST_WACK: begin
                  if (scl_fall_i) begin
                     oe_q <= 1'b0;
                     st_q <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_rise_i) begin
                     cnt_q <= cnt_q + 1'b1;
                  end else if (scl_fall_i) begin
                     if (cnt_q == FULL) begin
                        oe_q <= 1'b0;
                        st_q <= ST_MACK;
                     end else begin
                        oe_q <= ~sh_q[DATA_W-2];
                        sh_q <= {sh_q[DATA_W-2:0], 1'b0};
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise_i) begin
                     mack_q <= ~sda_lvl_i;
                  end else if (scl_fall_i) begin
                     cnt_q <= '0;
                     if (mack_q) begin
                        sh_q <= rd_data_i;
                        oe_q <= ~rd_data_i[DATA_W-1];
                        st_q <= ST_RD;
                     end else begin
                        st_q <= ST_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe_o   = oe_q;
   assign ptr_o      = ptr_q;
   assign wr_stb_o   = stb_q;
   assign wr_data_o  = wdat_q;
   assign lock_req_o = lock_q;

endmodule

// File: rtl/smb_strap_slave.sv
module smb_strap_slave #(
   parameter int         DATA_W      = 8,
   parameter int         ADDR_W      = 7,
   parameter int         HI_W        = 5,
   parameter logic [4:0] ADDR_HI     = 5'b01011,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic              strap_en_i,
   input  logic              strap_sel_i,
   output logic              pins_normal_o,
   output logic [DATA_W-1:0] reg_ptr_o,
   output logic              wr_stb_o,
   output logic [DATA_W-1:0] wr_data_o,
   input  logic [DATA_W-1:0] rd_data_i
);

   generate
      if (ADDR_W + 1 != DATA_W) begin : g_bad_width
         $error("smb_strap_slave: address plus direction bit must fill a byte");
      end
      if (HI_W >= ADDR_W) begin : g_bad_hi
         $error("smb_strap_slave: prefix must be shorter than the address");
      end
   endgenerate

   logic              scl_lvl, scl_prv;
   logic              sda_lvl, sda_prv;
   logic              scl_rise, scl_fall;
   logic              start_det, stop_det;
   logic              lock_req;
   logic              addr_locked;
   logic [ADDR_W-1:0] eff_addr;

   smb_line_sync #(.STAGES(SYNC_STAGES)) scl_sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .line_i(scl_i),
      .lvl_o (scl_lvl),
      .prv_o (scl_prv)
   );

   smb_line_sync #(.STAGES(SYNC_STAGES)) sda_sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .line_i(sda_i),
      .lvl_o (sda_lvl),
      .prv_o (sda_prv)
   );

   assign scl_rise  = scl_lvl & ~scl_prv;
   assign scl_fall  = ~scl_lvl & scl_prv;
   assign start_det = scl_lvl & scl_prv & sda_prv & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_prv & ~sda_prv & sda_lvl;

   smb_addr_strap #(
      .ADDR_W (ADDR_W),
      .HI_W   (HI_W),
      .ADDR_HI(ADDR_HI)
   ) addr_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .strap_en_i   (strap_en_i),
      .strap_sel_i  (strap_sel_i),
      .lock_req_i   (lock_req),
      .stop_i       (stop_det),
      .eff_addr_o   (eff_addr),
      .locked_o     (addr_locked),
      .pins_normal_o(pins_normal_o)
   );

   smb_byte_fsm #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .HI_W   (HI_W),
      .ADDR_HI(ADDR_HI)
   ) fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise_i(scl_rise),
      .scl_fall_i(scl_fall),
      .sda_lvl_i (sda_lvl),
      .start_i   (start_det),
      .stop_i    (stop_det),
      .eff_addr_i(eff_addr),
      .lock_req_o(lock_req),
      .sda_oe_o  (sda_oe_o),
      .ptr_o     (reg_ptr_o),
      .wr_stb_o  (wr_stb_o),
      .wr_data_o (wr_data_o),
      .rd_data_i (rd_data_i)
   );

endmodule

// File: rtl/smb_strap_slave_chk.sv
module smb_strap_slave_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_lvl,
   input logic              sda_oe,
   input logic              stop_det,
   input logic              locked,
   input logic [ADDR_W-1:0] eff_addr,
   input logic              pins_normal,
   input logic              wr_stb,
   input logic [DATA_W-1:0] reg_ptr
);

   // R8
   sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));

   // R9
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   // R4
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);

   // R4
   lock_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && $past(locked)) |-> $stable(eff_addr));

   // R5
   pins_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pins_normal |=> pins_normal);

   // R5
   pins_need_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pins_normal |-> locked);

   // R6
   stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   // R6
   ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> (reg_ptr == $past(reg_ptr) + DATA_W'(1)));

endmodule

bind smb_strap_slave smb_strap_slave_chk #(
   .DATA_W(DATA_W),
   .ADDR_W(ADDR_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_lvl    (scl_lvl),
   .sda_oe     (sda_oe_o),
   .stop_det   (stop_det),
   .locked     (addr_locked),
   .eff_addr   (eff_addr),
   .pins_normal(pins_normal_o),
   .wr_stb     (wr_stb_o),
   .reg_ptr    (reg_ptr_o)
);

// File: tb/smb_strap_slave_tb_top.sv
module smb_strap_slave_tb_top;

   localparam int H = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       msda = 1'b1;
   logic       strap_en = 1'b1;
   logic       strap_sel = 1'b0;
   logic       sda_oe;
   logic       pins_normal;
   logic [7:0] reg_ptr;
   logic       wr_stb;
   logic [7:0] wr_data;
   logic [7:0] rd_data;
   logic       bus_sda;

   int         n_chk = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   int         stb_n = 0;
   logic [7:0] cap_ptr [16];
   logic [7:0] cap_dat [16];

   always #5 clk = ~clk;

   assign bus_sda = msda & ~sda_oe;
   assign rd_data = reg_ptr ^ 8'h96;

   smb_strap_slave dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (scl),
      .sda_i        (bus_sda),
      .sda_oe_o     (sda_oe),
      .strap_en_i   (strap_en),
      .strap_sel_i  (strap_sel),
      .pins_normal_o(pins_normal),
      .reg_ptr_o    (reg_ptr),
      .wr_stb_o     (wr_stb),
      .wr_data_o    (wr_data),
      .rd_data_i    (rd_data)
   );

   always @(negedge clk) begin
      if (wr_stb && stb_n < 16) begin
         cap_ptr[stb_n] = reg_ptr;
         cap_dat[stb_n] = wr_data;
         stb_n = stb_n + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic do_reset(input logic en, input logic sel);
      rst_n = 1'b0;
      scl = 1'b1;
      msda = 1'b1;
      strap_en = en;
      strap_sel = sel;
      tick(4);
      rst_n = 1'b1;
      tick(4);
   endtask

   task automatic bus_start();
      msda = 1'b1; tick(H);
      scl = 1'b1;  tick(H);
      msda = 1'b0; tick(H);
      scl = 1'b0;  tick(H/2);
   endtask

   task automatic bus_stop();
      msda = 1'b0; tick(H);
      scl = 1'b1;  tick(H);
      msda = 1'b1; tick(H);
   endtask

   task automatic bit_out(input logic b);
      msda = b;   tick(H);
      scl = 1'b1; tick(H);
      scl = 1'b0; tick(H/2);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      msda = 1'b1; tick(H);
      scl = 1'b1;  tick(H/2);
      acked = ~bus_sda;
      tick(H/2);
      scl = 1'b0;  tick(H/2);
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d, output logic stable);
      logic s1, s2;
      stable = 1'b1;
      d = '0;
      for (int i = 7; i >= 0; i--) begin
         msda = 1'b1; tick(H);
         scl = 1'b1;  tick(3);
         s1 = bus_sda;
         tick(H - 6);
         s2 = bus_sda;
         tick(3);
         scl = 1'b0;  tick(H/2);
         d[i] = s1;
         if (s1 !== s2) stable = 1'b0;
      end
      bit_out(~give_ack);
   endtask

   // R1
   task automatic t_reset_state();
      do_reset(1'b1, 1'b0);
      chk("R1 sda_oe", sda_oe, 0);
      chk("R1 pins_normal", pins_normal, 0);
      chk("R1 wr_stb", wr_stb, 0);
   endtask

   // R2 and R5
   task automatic t_strap_map();
      logic a;
      do_reset(1'b0, 1'b0);
      bus_start(); send_byte(8'h58, a); chk("R2 both straps low -> 2C ack", a, 1);
      chk("R5 pins kept before stop", pins_normal, 0);
      bus_stop();
      chk("R5 pins returned after stop", pins_normal, 1);
      do_reset(1'b0, 1'b1);
      bus_start(); send_byte(8'h5A, a); chk("R2 select high -> 2D ack", a, 1);
      bus_stop();
      do_reset(1'b1, 1'b1);
      bus_start(); send_byte(8'h5A, a); chk("R2 enable high ignores select (2D nack)", a, 0);
      bus_stop();
      bus_start(); send_byte(8'h5C, a); chk("R2 enable high -> 2E ack", a, 1);
      bus_stop();
   endtask

   // R3, R4, R10, R5
   task automatic t_glitch_lock();
      logic a;
      do_reset(1'b1, 1'b0);
      bus_start(); send_byte(8'hA0, a); chk("R3 foreign prefix nack", a, 0);
      bus_stop();
      chk("R3 no lock so pins kept", pins_normal, 0);
      strap_en = 1'b0; strap_sel = 1'b1;
      bus_start(); send_byte(8'h5C, a); chk("R10 prefix match, address 2E vs strap 2D nack", a, 0);
      bus_stop();
      chk("R5 pins returned after locking transaction", pins_normal, 1);
      strap_en = 1'b1; strap_sel = 1'b0;
      bus_start(); send_byte(8'h5C, a); chk("R4 strap change ignored after lock (2E nack)", a, 0);
      bus_stop();
      bus_start(); send_byte(8'h5A, a); chk("R4 locked address 2D still acked", a, 1);
      bus_stop();
      chk("R5 pins stay returned", pins_normal, 1);
   endtask

   // R6
   task automatic t_write();
      logic a;
      int   s0;
      do_reset(1'b1, 1'b0);
      s0 = stb_n;
      bus_start(); send_byte(8'h5C, a);
      send_byte(8'h10, a); chk("R6 pointer byte acked", a, 1);
      chk("R6 pointer byte gives no strobe", stb_n - s0, 0);
      chk("R6 pointer loaded", reg_ptr, 8'h10);
      send_byte(8'hA5, a); chk("R6 data byte acked", a, 1);
      send_byte(8'h3C, a);
      bus_stop();
      chk("R6 strobe count", stb_n - s0, 2);
      chk("R6 first strobe pointer", cap_ptr[s0], 8'h10);
      chk("R6 first strobe data", cap_dat[s0], 8'hA5);
      chk("R6 second strobe pointer", cap_ptr[s0+1], 8'h11);
      chk("R6 second strobe data", cap_dat[s0+1], 8'h3C);
      chk("R6 pointer after writes", reg_ptr, 8'h12);
   endtask

   // R7, R8, R9
   task automatic t_read();
      logic       a, st;
      logic [7:0] d;
      do_reset(1'b1, 1'b0);
      bus_start(); send_byte(8'h5C, a); send_byte(8'h20, a);
      bus_start(); send_byte(8'h5D, a); chk("R9 repeated start read address acked", a, 1);
      recv_byte(1'b1, d, st);
      chk("R7 first read byte", d, 8'h20 ^ 8'h96);
      chk("R8 data stable while clock high", st, 1);
      recv_byte(1'b0, d, st);
      chk("R7 second read byte same pointer", d, 8'h20 ^ 8'h96);
      chk("R7 released after master nack", sda_oe, 0);
      bus_stop();
   endtask

   // R9
   task automatic t_stop_abort();
      logic a;
      int   s0;
      do_reset(1'b1, 1'b0);
      s0 = stb_n;
      bus_start(); send_byte(8'h5C, a); send_byte(8'h40, a);
      bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
      bus_stop();
      chk("R9 data released after stop", sda_oe, 0);
      chk("R9 partial byte dropped", stb_n - s0, 0);
      bus_start(); send_byte(8'h5C, a); chk("R9 fresh address after stop acked", a, 1);
      send_byte(8'h41, a); send_byte(8'h77, a);
      bus_stop();
      chk("R9 strobe after recovery", stb_n - s0, 1);
      chk("R9 recovered write data", cap_dat[s0], 8'h77);
      chk("R9 recovered write pointer", cap_ptr[s0], 8'h41);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_strap_map();
      t_glitch_lock();
      t_write();
      t_read();
      t_stop_abort();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule